// File: doc/BRIEF.md
# Fixed I/O Port Decode Router

This block sits in front of a set of legacy I/O units and decides, for each I/O read or write, which single unit receives it. A request carries a 16-bit port address, byte enables, a direction flag and write data. The block returns one registered response per accepted request, one cycle after the handshake. The response holds a destination vector and the effective port address after aliasing. A few configuration inputs change the result: they turn on port aliasing, choose between the serial peripheral bus and a PCIe port, and gate the ports that are forwarded off-chip.

A request that no unit claims is completed inside the block. Reads of such a port return all ones in the enabled byte lanes, and writes go nowhere. The one exception to single-target delivery is a write to port 70h, which reaches both the NMI control unit and the RTC unit.

Decoding always uses the starting address, so a word or doubleword access that begins at a port is decoded as an access to that port.

Top module: `fixio_router`

## Requirements
- R1: `req_ready` is low while `rst` is high and high otherwise. `rsp_valid` is low in reset. It goes high for exactly one cycle, in the cycle after each accepted request (`req_valid` and `req_ready`), and stays low otherwise.
- R2: `rsp_dest` is a one-hot vector with these bit positions: 0 terminated, 1 interrupt controller, 2 timer, 3 NMI control, 4 RTC, 5 reset generator, 6 power management, 7 serial peripheral bus, 8 PCIe. Exactly one bit is set in every response except the dual-target case of R8.
- R3: Any port not claimed under R4 to R12 sets only bit 0, and `rsp_addr` echoes the request address. For a terminated read, `rsp_rdata` is FFh in each byte lane whose `req_be` bit is 1 and 00h in every other lane. For every other response `rsp_rdata` is 0.
- R4: These ports go to the interrupt controller: 20h–21h, 24h–25h, 28h–29h, 2Ch–2Dh, 30h–31h, 34h–35h, 38h–39h, 3Ch–3Dh, the same eight pairs at A0h–BDh, and 4D0h–4D1h. Ports B2h–B3h go to power management instead.
- R5: Ports 40h, 42h, 43h, 50h, 52h and 53h go to the timer. Ports 92h and CF9h go to the reset generator. Ports B2h and B3h go to power management.
- R6: Port 61h goes to NMI control. Ports 63h, 65h and 67h go to NMI control with effective address 61h when `cfg_nmi_alias_en` is 1, and are terminated when it is 0.
- R7: Ports 70h–77h go to the RTC. When `cfg_rtc_upper_en` is 0, ports 72h, 73h, 76h and 77h take effective address 70h, 71h, 70h and 71h. When it is 1, every port keeps its own address.
- R8: A write whose effective address is 70h sets both bit 3 and bit 4. A read of 70h sets bit 4 only.
- R9: Ports 80h, 84h–86h, 88h and 8Ch–8Eh go to PCIe (bit 8) when `cfg_pcie_route` is 1, and to the serial bus (bit 7) when it is 0.
- R10: Ports 90h, 94h–96h, 98h and 9Ch–9Eh always go to the serial bus, with effective address 10h lower (90h→80h, 9Dh→8Dh).
- R11: Ports 60h and 64h go to the serial bus only when `cfg_kbd_en` is 1. Ports 62h and 66h go there only when `cfg_mcu_en` is 1. Ports 2Eh–2Fh depend on `cfg_sio_en` and ports 4Eh–4Fh on `cfg_mcu2_en`. When the governing enable is 0, the port is terminated.
- R12: Ports 200h–207h go to the serial bus when `cfg_game_lo_en` is 1, and ports 208h–20Fh when `cfg_game_hi_en` is 1. Otherwise they are terminated.
- R13: Decoding uses only the starting address, whatever `req_be` holds. A doubleword access at 80h decodes exactly as a byte access at 80h. `rsp_write`, `rsp_be` and `rsp_wdata` echo the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 16 | I/O port address (start of access) |
| req_be | input | 4 | Byte enables |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| cfg_nmi_alias_en | input | 1 | Alias 63h/65h/67h onto 61h |
| cfg_rtc_upper_en | input | 1 | Keep 72h/73h/76h/77h as own addresses |
| cfg_pcie_route | input | 1 | Route port-80 group to PCIe |
| cfg_kbd_en | input | 1 | Enable 60h/64h forwarding |
| cfg_mcu_en | input | 1 | Enable 62h/66h forwarding |
| cfg_sio_en | input | 1 | Enable 2Eh–2Fh forwarding |
| cfg_mcu2_en | input | 1 | Enable 4Eh–4Fh forwarding |
| cfg_game_lo_en | input | 1 | Enable 200h–207h forwarding |
| cfg_game_hi_en | input | 1 | Enable 208h–20Fh forwarding |
| rsp_valid | output | 1 | Response pulse |
| rsp_dest | output | 9 | One-hot destination vector |
| rsp_addr | output | 16 | Effective port address |
| rsp_write | output | 1 | Echoed direction |
| rsp_be | output | 4 | Echoed byte enables |
| rsp_wdata | output | 32 | Echoed write data |
| rsp_rdata | output | 32 | Read data for terminated reads |

## Verification
In a single response, aliasing and dual-target delivery can both act. When the upper RTC bank is off, a write to 72h or 76h is first remapped to 70h and must then reach both NMI control and the RTC. A read of the same port must reach the RTC alone. The bench drives writes and reads to 72h and 76h with the upper-bank enable in both states, and checks the destination vector and the effective address in each response. Termination and byte-lane masking also meet in one cycle. The bench sends reads to unclaimed ports with partial byte enables and compares the returned lanes.

// File: rtl/fixio_pkg.sv
package fixio_pkg;
  localparam int NDEST   = 9;
  localparam int D_TERM  = 0;
  localparam int D_PIC   = 1;
  localparam int D_TMR   = 2;
  localparam int D_NMI   = 3;
  localparam int D_RTC   = 4;
  localparam int D_RST   = 5;
  localparam int D_PM    = 6;
  localparam int D_SBUS  = 7;
  localparam int D_PCIE  = 8;

  typedef struct packed {
    logic nmi_alias_en;
    logic rtc_upper_en;
    logic pcie_route;
    logic kbd_en;
    logic mcu_en;
    logic sio_en;
    logic mcu2_en;
    logic game_lo_en;
    logic game_hi_en;
  } fixio_cfg_t;
endpackage

// File: rtl/fixio_classify.sv
module fixio_classify
  import fixio_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  fixio_cfg_t        cfg,
  output logic [NDEST-1:0]  dest,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int HI_W = ADDR_W - 8;

  logic [7:0]      lo;
  logic [HI_W-1:0] hi;
  logic            p80_shape;

  assign lo = addr[7:0];
  assign hi = addr[ADDR_W-1:8];
  // low nibble in {0,4,5,6,8,C,D,E}
  assign p80_shape = (lo[2:0] == 3'b000) || (lo[2] && (lo[1:0] != 2'b11));

  always_comb begin
    dest     = '0;
    eff_addr = addr;
    if (hi == '0) begin
      if (((lo[7:5] == 3'b001) || (lo[7:5] == 3'b101)) && !lo[1]) begin
        dest[D_PIC] = 1'b1;
      end else if ((lo & 8'hEF) == 8'h40 || (lo & 8'hEF) == 8'h42 ||
                   (lo & 8'hEF) == 8'h43) begin
        dest[D_TMR] = 1'b1;
      end else if (lo == 8'h2E || lo == 8'h2F) begin
        dest[D_SBUS] = cfg.sio_en;
      end else if (lo == 8'h4E || lo == 8'h4F) begin
        dest[D_SBUS] = cfg.mcu2_en;
      end else if (lo == 8'h60 || lo == 8'h64) begin
        dest[D_SBUS] = cfg.kbd_en;
      end else if (lo == 8'h62 || lo == 8'h66) begin
        dest[D_SBUS] = cfg.mcu_en;
      end else if (lo == 8'h61) begin
        dest[D_NMI] = 1'b1;
      end else if (lo == 8'h63 || lo == 8'h65 || lo == 8'h67) begin
        if (cfg.nmi_alias_en) begin
          dest[D_NMI] = 1'b1;
          eff_addr    = ADDR_W'(16'h0061);
        end
      end else if (lo[7:3] == 5'b01110) begin
        if (!cfg.rtc_upper_en && lo[1]) eff_addr = {addr[ADDR_W-1:3], 3'b000} | ADDR_W'(addr[0]);
        dest[D_RTC] = 1'b1;
        if (write && eff_addr == ADDR_W'(16'h0070)) dest[D_NMI] = 1'b1;
      end else if (lo[7:4] == 4'h8 && p80_shape) begin
        if (cfg.pcie_route) dest[D_PCIE] = 1'b1;
        else                dest[D_SBUS] = 1'b1;
      end else if (lo[7:4] == 4'h9 && p80_shape) begin
        dest[D_SBUS] = 1'b1;
        eff_addr     = addr & ~ADDR_W'(16'h0010);
      end else if (lo == 8'h92) begin
        dest[D_RST] = 1'b1;
      end else if (lo == 8'hB2 || lo == 8'hB3) begin
        dest[D_PM] = 1'b1;
      end
    end else if (addr == ADDR_W'(16'h04D0) || addr == ADDR_W'(16'h04D1)) begin
      dest[D_PIC] = 1'b1;
    end else if (addr == ADDR_W'(16'h0CF9)) begin
      dest[D_RST] = 1'b1;
    end else if (addr[ADDR_W-1:4] == (ADDR_W-4)'(12'h020)) begin
      dest[D_SBUS] = addr[3] ? cfg.game_hi_en : cfg.game_lo_en;
    end
    if (dest == '0) begin
      dest[D_TERM] = 1'b1;
      eff_addr     = addr;
    end
  end
endmodule

// File: rtl/fixio_term_data.sv
module fixio_term_data #(
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              term,
  input  logic              write,
  input  logic [BE_W-1:0]   be,
  output logic [DATA_W-1:0] rdata
);
  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign rdata[i*8 +: 8] = (term && !write && be[i]) ? 8'hFF : 8'h00;
  end
endmodule

// File: rtl/fixio_router.sv
module fixio_router
  import fixio_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              cfg_nmi_alias_en,
  input  logic              cfg_rtc_upper_en,
  input  logic              cfg_pcie_route,
  input  logic              cfg_kbd_en,
  input  logic              cfg_mcu_en,
  input  logic              cfg_sio_en,
  input  logic              cfg_mcu2_en,
  input  logic              cfg_game_lo_en,
  input  logic              cfg_game_hi_en,
  output logic              rsp_valid,
  output logic [NDEST-1:0]  rsp_dest,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_write,
  output logic [BE_W-1:0]   rsp_be,
  output logic [DATA_W-1:0] rsp_wdata,
  output logic [DATA_W-1:0] rsp_rdata
);
  fixio_cfg_t        cfg;
  logic [NDEST-1:0]  dec_dest;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_rdata;
  logic              accept;

  assign cfg = '{nmi_alias_en: cfg_nmi_alias_en, rtc_upper_en: cfg_rtc_upper_en,
                 pcie_route: cfg_pcie_route, kbd_en: cfg_kbd_en, mcu_en: cfg_mcu_en,
                 sio_en: cfg_sio_en, mcu2_en: cfg_mcu2_en,
                 game_lo_en: cfg_game_lo_en, game_hi_en: cfg_game_hi_en};

  assign req_ready = !rst;
  assign accept    = req_valid && req_ready;

  fixio_classify #(.ADDR_W(ADDR_W)) u_classify (
    .addr(req_addr), .write(req_write), .cfg(cfg),
    .dest(dec_dest), .eff_addr(dec_addr)
  );

  fixio_term_data #(.DATA_W(DATA_W)) u_term (
    .term(dec_dest[D_TERM]), .write(req_write), .be(req_be), .rdata(dec_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_dest  <= '0;
      rsp_addr  <= '0;
      rsp_write <= 1'b0;
      rsp_be    <= '0;
      rsp_wdata <= '0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_dest  <= dec_dest;
        rsp_addr  <= dec_addr;
        rsp_write <= req_write;
        rsp_be    <= req_be;
        rsp_wdata <= req_wdata;
        rsp_rdata <= dec_rdata;
      end
    end
  end

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    accept |=> rsp_valid) else $error("rsp missing");                       // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !accept |=> !rsp_valid) else $error("spurious rsp");                    // R1
  AST_DEST_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !(rsp_write && rsp_addr == ADDR_W'(16'h0070)) |-> $onehot0(rsp_dest) && rsp_dest != '0)
    else $error("dest not one-hot");                                        // R2
  AST_DUAL_ONLY_P70W: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && $countones(rsp_dest) == 2 |->
      rsp_write && rsp_addr == ADDR_W'(16'h0070) && rsp_dest[D_NMI] && rsp_dest[D_RTC])
    else $error("bad dual target");                                         // R8
  AST_CLAIMED_NO_RDATA: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_dest[D_TERM] |-> rsp_rdata == '0) else $error("rdata leak"); // R3
  AST_TERM_FULL_ONES: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_dest[D_TERM] && !rsp_write && rsp_be == '1 |-> rsp_rdata == '1)
    else $error("term rdata");                                              // R3
  AST_NMI_ADDR: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_dest[D_NMI] |-> rsp_addr == ADDR_W'(16'h0061) || rsp_addr == ADDR_W'(16'h0070))
    else $error("nmi addr");                                                // R6
endmodule

// File: tb/tb_fixio_router.sv
module tb_fixio_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        c_alias = 1, c_upper = 0, c_pcie = 0, c_kbd = 1, c_mcu = 1,
               c_sio = 1, c_mcu2 = 1, c_glo = 1, c_ghi = 1;
  logic        rsp_valid, rsp_write;
  logic [8:0]  rsp_dest;
  logic [15:0] rsp_addr;
  logic [3:0]  rsp_be;
  logic [31:0] rsp_wdata, rsp_rdata;

  int errors = 0, checks = 0;

  localparam logic [8:0] TERM = 9'h001, PIC = 9'h002, TMR = 9'h004, NMI = 9'h008,
                         RTC = 9'h010, RSTG = 9'h020, PM = 9'h040, SBUS = 9'h080, PCIE = 9'h100;

  fixio_router dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be), .req_write(req_write), .req_wdata(req_wdata),
    .cfg_nmi_alias_en(c_alias), .cfg_rtc_upper_en(c_upper), .cfg_pcie_route(c_pcie),
    .cfg_kbd_en(c_kbd), .cfg_mcu_en(c_mcu), .cfg_sio_en(c_sio), .cfg_mcu2_en(c_mcu2),
    .cfg_game_lo_en(c_glo), .cfg_game_hi_en(c_ghi),
    .rsp_valid(rsp_valid), .rsp_dest(rsp_dest), .rsp_addr(rsp_addr), .rsp_write(rsp_write),
    .rsp_be(rsp_be), .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic ok, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one request, response sampled at the negedge after the accepting posedge
  task automatic xfer(input string tag, input logic [15:0] a, input logic [3:0] be,
                      input logic wr, input logic [8:0] edest, input logic [15:0] eaddr,
                      input logic [31:0] erd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_be = be; req_write = wr;
    req_wdata = {16'hC0DE, a};
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, rsp_valid === 1'b1, "rsp_valid", {31'd0, rsp_valid}, 32'd1);
    chk(tag, rsp_dest === edest, $sformatf("dest@%h", a), {23'd0, rsp_dest}, {23'd0, edest});
    chk(tag, rsp_addr === eaddr, $sformatf("addr@%h", a), {16'd0, rsp_addr}, {16'd0, eaddr});
    chk(tag, rsp_rdata === erd, $sformatf("rdata@%h", a), rsp_rdata, erd);
  endtask

  task automatic t_reset_and_handshake;
    chk("R1", req_ready === 1'b0 && rsp_valid === 1'b0, "reset state",
        {30'd0, req_ready, rsp_valid}, 32'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R1", req_ready === 1'b1, "ready after reset", {31'd0, req_ready}, 32'd1);
    xfer("R1", 16'h0061, 4'h1, 1'b0, NMI, 16'h0061, 32'h0);
    @(negedge clk);
    chk("R1", rsp_valid === 1'b0, "pulse width", {31'd0, rsp_valid}, 32'd0);
  endtask

  task automatic t_terminated;
    xfer("R3", 16'h0010, 4'hF, 1'b0, TERM, 16'h0010, 32'hFFFF_FFFF);
    xfer("R3", 16'h0300, 4'h5, 1'b0, TERM, 16'h0300, 32'h00FF_00FF);
    xfer("R3", 16'h0041, 4'hF, 1'b0, TERM, 16'h0041, 32'hFFFF_FFFF);
    xfer("R3", 16'h0022, 4'h2, 1'b0, TERM, 16'h0022, 32'h0000_FF00);
    xfer("R3", 16'h0081, 4'hF, 1'b1, TERM, 16'h0081, 32'h0);
    xfer("R2", 16'h0071, 4'h1, 1'b0, RTC, 16'h0071, 32'h0);
  endtask

  task automatic t_fixed_units;
    xfer("R4", 16'h0020, 4'h1, 1'b0, PIC, 16'h0020, 0);
    xfer("R4", 16'h003D, 4'h1, 1'b1, PIC, 16'h003D, 0);
    xfer("R4", 16'h00A1, 4'h1, 1'b0, PIC, 16'h00A1, 0);
    xfer("R4", 16'h00BC, 4'h1, 1'b0, PIC, 16'h00BC, 0);
    xfer("R4", 16'h04D1, 4'h1, 1'b0, PIC, 16'h04D1, 0);
    xfer("R5", 16'h0040, 4'h1, 1'b0, TMR, 16'h0040, 0);
    xfer("R5", 16'h0053, 4'h1, 1'b1, TMR, 16'h0053, 0);
    xfer("R5", 16'h0051, 4'h1, 1'b0, TERM, 16'h0051, 32'h0000_00FF);
    xfer("R5", 16'h0092, 4'h1, 1'b1, RSTG, 16'h0092, 0);
    xfer("R5", 16'h0CF9, 4'h1, 1'b1, RSTG, 16'h0CF9, 0);
    xfer("R5", 16'h00B2, 4'h1, 1'b1, PM, 16'h00B2, 0);
    xfer("R5", 16'h00B3, 4'h1, 1'b0, PM, 16'h00B3, 0);
  endtask

  task automatic t_nmi_alias;
    c_alias = 1'b1;
    xfer("R6", 16'h0063, 4'h1, 1'b1, NMI, 16'h0061, 0);
    xfer("R6", 16'h0067, 4'h1, 1'b0, NMI, 16'h0061, 0);
    c_alias = 1'b0;
    xfer("R6", 16'h0065, 4'h1, 1'b0, TERM, 16'h0065, 32'h0000_00FF);
    xfer("R6", 16'h0061, 4'h1, 1'b1, NMI, 16'h0061, 0);
    c_alias = 1'b1;
  endtask

  task automatic t_rtc_and_dual;
    c_upper = 1'b0;
    xfer("R7", 16'h0073, 4'h1, 1'b0, RTC, 16'h0071, 0);
    xfer("R7", 16'h0077, 4'h1, 1'b0, RTC, 16'h0071, 0);
    xfer("R7", 16'h0074, 4'h1, 1'b0, RTC, 16'h0074, 0);
    xfer("R8", 16'h0070, 4'h1, 1'b1, NMI | RTC, 16'h0070, 0);
    xfer("R8", 16'h0070, 4'h1, 1'b0, RTC, 16'h0070, 0);
    xfer("R8", 16'h0072, 4'h1, 1'b1, NMI | RTC, 16'h0070, 0);
    xfer("R8", 16'h0076, 4'h1, 1'b0, RTC, 16'h0070, 0);
    c_upper = 1'b1;
    xfer("R7", 16'h0072, 4'h1, 1'b1, RTC, 16'h0072, 0);
    xfer("R7", 16'h0077, 4'h1, 1'b0, RTC, 16'h0077, 0);
    xfer("R8", 16'h0076, 4'h1, 1'b1, RTC, 16'h0076, 0);
    c_upper = 1'b0;
  endtask

  task automatic t_port80;
    c_pcie = 1'b0;
    xfer("R9", 16'h0080, 4'h1, 1'b1, SBUS, 16'h0080, 0);
    xfer("R9", 16'h008E, 4'h1, 1'b0, SBUS, 16'h008E, 0);
    c_pcie = 1'b1;
    xfer("R9", 16'h0085, 4'h1, 1'b1, PCIE, 16'h0085, 0);
    xfer("R13", 16'h0080, 4'hF, 1'b1, PCIE, 16'h0080, 0);
    xfer("R13", 16'h0080, 4'h3, 1'b0, PCIE, 16'h0080, 0);
    chk("R13", rsp_be === 4'h3 && rsp_write === 1'b0 && rsp_wdata === 32'hC0DE_0080,
        "echo", {rsp_be, rsp_wdata[27:0]}, {4'h3, 28'hDE_0080});
    xfer("R10", 16'h0090, 4'h1, 1'b1, SBUS, 16'h0080, 0);
    xfer("R10", 16'h009D, 4'h1, 1'b0, SBUS, 16'h008D, 0);
    xfer("R10", 16'h0098, 4'h1, 1'b0, SBUS, 16'h0088, 0);
    xfer("R10", 16'h0097, 4'h1, 1'b0, TERM, 16'h0097, 32'h0000_00FF);
    c_pcie = 1'b0;
  endtask

  task automatic t_enables;
    c_kbd = 1'b0;
    xfer("R11", 16'h0060, 4'h1, 1'b0, TERM, 16'h0060, 32'h0000_00FF);
    xfer("R11", 16'h0064, 4'h1, 1'b1, TERM, 16'h0064, 0);
    c_kbd = 1'b1;
    xfer("R11", 16'h0064, 4'h1, 1'b1, SBUS, 16'h0064, 0);
    c_mcu = 1'b0;
    xfer("R11", 16'h0066, 4'h1, 1'b0, TERM, 16'h0066, 32'h0000_00FF);
    c_mcu = 1'b1;
    xfer("R11", 16'h0062, 4'h1, 1'b0, SBUS, 16'h0062, 0);
    c_sio = 1'b0;
    xfer("R11", 16'h002F, 4'h1, 1'b0, TERM, 16'h002F, 32'h0000_00FF);
    xfer("R11", 16'h004E, 4'h1, 1'b0, SBUS, 16'h004E, 0);
    c_sio = 1'b1; c_mcu2 = 1'b0;
    xfer("R11", 16'h004F, 4'h1, 1'b0, TERM, 16'h004F, 32'h0000_00FF);
    xfer("R11", 16'h002E, 4'h1, 1'b0, SBUS, 16'h002E, 0);
    c_mcu2 = 1'b1;
  endtask

  task automatic t_game;
    xfer("R12", 16'h0200, 4'h1, 1'b0, SBUS, 16'h0200, 0);
    xfer("R12", 16'h020F, 4'h1, 1'b0, SBUS, 16'h020F, 0);
    c_glo = 1'b0;
    xfer("R12", 16'h0207, 4'h1, 1'b0, TERM, 16'h0207, 32'h0000_00FF);
    xfer("R12", 16'h0208, 4'h1, 1'b0, SBUS, 16'h0208, 0);
    c_glo = 1'b1; c_ghi = 1'b0;
    xfer("R12", 16'h020A, 4'h1, 1'b0, TERM, 16'h020A, 32'h0000_00FF);
    xfer("R12", 16'h0210, 4'h1, 1'b0, TERM, 16'h0210, 32'h0000_00FF);
    c_ghi = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_and_handshake();
    t_terminated();
    t_fixed_units();
    t_nmi_alias();
    t_rtc_and_dual();
    t_port80();
    t_enables();
    t_game();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule